// File: doc/BRIEF.md
# Mode-Switched Shift-Register Entropy Conditioner

This block takes a stream of raw, possibly biased and correlated bits from a physical noise sampler and turns it into a thinner stream of well-mixed bits. It runs on the sampler's own clock. It is built from three shift-register stages in series. The first stage is a 31-bit register that absorbs each raw bit into its feedback. Its lowest state bits then choose how a 32-bit mixing register steps on the same cycle. A divide-by-two gate lets every second accepted bit through to a final 32-bit mixing register, whose lowest state bit is the conditioned output.

Each mixing register has eight ways to step. There are four fixed tap masks, and each can run with plain or inverted feedback. Data bits pick the way on every step, so the state jumps between eight tangled trajectories rather than following one. Two raw bits in give one conditioned bit out, at a fixed rate, and a downstream deterministic generator can use that bit as seed material.

Top module: `entropy_conditioner`

## Requirements
- R1: A synchronous active-high reset loads stage one with 31'h1A5C3E17, stage two with 32'h6C8E9D31, stage three with 32'hB7D34A05, and clears the decimator phase and `cond_valid`. After reset, `cond_bit` is 1 and `cond_valid` is 0.
- R2: Every stage steps by a right-shift with a selectable mask. The feedback bit is f = s[0] ^ d ^ i, and the next state is (s >> 1) ^ (f ? mask : 0). Stage one uses d = `raw_bit`, i = 0 and mask 31'h48000000, and steps on every cycle with `raw_valid` high.
- R3: Stage two steps on every cycle with `raw_valid` high, with d = 0. Its mode is taken from stage one's state before that same step: coefficient index = stage-one bits [1:0], and i = `raw_bit`.
- R4: The decimator accepts raw bits in pairs. A phase bit toggles on every accepted bit. Stage three steps only on the second bit of each pair (phase 1), with d = 0, coefficient index = stage-two state bits [1:0] and i = stage-two bit [2], all taken before that cycle's stage-two step. After reset the next accepted bit is the first of a pair.
- R5: `cond_valid` is high for exactly the one cycle after each stage-three step, and `cond_bit` always equals stage three's bit 0. `cond_bit` changes only in a cycle where `cond_valid` is high.
- R6: In a cycle with `raw_valid` low, no stage and no phase changes state, and `cond_valid` goes low on the next cycle.
- R7: When i = 1 the feedback bit is inverted (the XNOR form). A mixing register fed only inverted modes therefore follows a different trajectory from one fed plain modes.
- R8: The coefficient index chooses the mixing mask in this order: 0 → 32'h80200003, 1 → 32'hA3000000, 2 → 32'hD0000001, 3 → 32'h80000057.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampler clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bit | input | 1 | Raw bit from the noise source |
| raw_valid | input | 1 | Raw bit is present this cycle |
| cond_bit | output | 1 | Conditioned bit (bit 0 of stage three) |
| cond_valid | output | 1 | Pulse marking a new conditioned bit |

## Verification
A constant stream of zeros keeps stage-two inversion off and exercises the plain feedback path and the mask order. A constant stream of ones forces the inverted form on every stage-two step, so it separates the XNOR path from the XOR path. Alternating and random streams sweep all four coefficient indices. Random gaps in `raw_valid` check that idle cycles freeze every stage and the pairing phase, and a reset in the middle of a run checks that all seeds and the phase are restored.

// File: rtl/entcond_pkg.sv
package entcond_pkg;

    localparam int RAW_W    = 31;
    localparam int MIX_W    = 32;
    localparam int NUM_COEF = 4;
    localparam int SEL_W    = $clog2(NUM_COEF);

    typedef logic [SEL_W-1:0] coef_sel_t;

    typedef struct packed {
        logic      inv;
        coef_sel_t coef;
    } step_mode_t;

    localparam int MODE_W = $bits(step_mode_t);

    typedef logic [NUM_COEF-1:0][MIX_W-1:0] mask_set_t;

    localparam mask_set_t MIX_MASKS = {
        32'h80000057,
        32'hD0000001,
        32'hA3000000,
        32'h80200003
    };

    localparam logic [MIX_W-1:0] RAW_MASK = 32'h48000000;

    localparam logic [RAW_W-1:0] SEED_ONE   = 31'h1A5C3E17;
    localparam logic [MIX_W-1:0] SEED_TWO   = 32'h6C8E9D31;
    localparam logic [MIX_W-1:0] SEED_THREE = 32'hB7D34A05;

    function automatic step_mode_t make_mode(input logic inv, input coef_sel_t coef);
        step_mode_t m;
        m.inv  = inv;
        m.coef = coef;
        return m;
    endfunction

endpackage

// File: rtl/ent_lfsr_stage.sv
module ent_lfsr_stage
    import entcond_pkg::*;
#(
    parameter int        W     = 32,
    parameter logic [W-1:0] SEED = '1,
    parameter mask_set_t MASKS = MIX_MASKS
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       din,
    input  step_mode_t mode,
    output logic [2:0] low_bits
);

    logic [W-1:0] state_q;
    logic [W-1:0] state_d;
    logic [W-1:0] sel_mask;
    logic         fb;

    always_comb begin
        sel_mask = MASKS[mode.coef][W-1:0];
        fb       = state_q[0] ^ din ^ mode.inv;
        state_d  = (state_q >> 1) ^ (fb ? sel_mask : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (en) begin
            state_q <= state_d;
        end
    end

    assign low_bits = state_q[2:0];

    assert_seed_load_R1: assert property (@(posedge clk)
        rst |=> (state_q == SEED));

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state_q));

endmodule

// File: rtl/ent_decimator.sv
module ent_decimator (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic take
);

    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
        end else if (in_valid) begin
            phase_q <= ~phase_q;
        end
    end

    assign take = in_valid & phase_q;

    assert_phase_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase_q));

    assert_pair_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

endmodule

// File: rtl/entropy_conditioner.sv
module entropy_conditioner
    import entcond_pkg::*;
#(
    parameter logic [RAW_W-1:0] SEED_A = SEED_ONE,
    parameter logic [MIX_W-1:0] SEED_B = SEED_TWO,
    parameter logic [MIX_W-1:0] SEED_C = SEED_THREE
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_bit,
    input  logic raw_valid,
    output logic cond_bit,
    output logic cond_valid
);

    localparam mask_set_t RAW_SET = {NUM_COEF{RAW_MASK}};

    logic [2:0] a_low;
    logic [2:0] b_low;
    logic [2:0] c_low;
    logic       take;
    logic       cond_valid_q;
    step_mode_t mode_a;
    step_mode_t mode_b;
    step_mode_t mode_c;

    always_comb begin
        mode_a = make_mode(1'b0, '0);
        mode_b = make_mode(raw_bit, a_low[SEL_W-1:0]);
        mode_c = make_mode(b_low[2], b_low[SEL_W-1:0]);
    end

    ent_lfsr_stage #(.W(RAW_W), .SEED(SEED_A), .MASKS(RAW_SET)) stage_a_i (
        .clk(clk), .rst(rst), .en(raw_valid), .din(raw_bit),
        .mode(mode_a), .low_bits(a_low)
    );

    ent_lfsr_stage #(.W(MIX_W), .SEED(SEED_B), .MASKS(MIX_MASKS)) stage_b_i (
        .clk(clk), .rst(rst), .en(raw_valid), .din(1'b0),
        .mode(mode_b), .low_bits(b_low)
    );

    ent_decimator decim_i (
        .clk(clk), .rst(rst), .in_valid(raw_valid), .take(take)
    );

    ent_lfsr_stage #(.W(MIX_W), .SEED(SEED_C), .MASKS(MIX_MASKS)) stage_c_i (
        .clk(clk), .rst(rst), .en(take), .din(1'b0),
        .mode(mode_c), .low_bits(c_low)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_valid_q <= 1'b0;
        end else begin
            cond_valid_q <= take;
        end
    end

    assign cond_valid = cond_valid_q;
    assign cond_bit   = c_low[0];

    assert_valid_needs_input_R4: assert property (@(posedge clk) disable iff (rst)
        cond_valid |-> $past(raw_valid));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
        cond_valid |=> !cond_valid);

    assert_bit_moves_with_valid_R5: assert property (@(posedge clk) disable iff (rst)
        (cond_bit != $past(cond_bit)) |-> cond_valid);

endmodule

// File: tb/entropy_conditioner_tb_top.sv
module entropy_conditioner_tb_top;

    localparam time CYC = 20ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw_bit = 1'b0;
    logic raw_valid = 1'b0;
    logic cond_bit;
    logic cond_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [31:0] ma, mb, mc;
    logic        mphase;
    logic        exp_valid;

    always #(CYC/2) clk = ~clk;

    entropy_conditioner dut_i (
        .clk(clk), .rst(rst), .raw_bit(raw_bit), .raw_valid(raw_valid),
        .cond_bit(cond_bit), .cond_valid(cond_valid)
    );

    function automatic logic [31:0] mix_mask(input logic [1:0] idx);
        case (idx)
            2'd0: return 32'h80200003;
            2'd1: return 32'hA3000000;
            2'd2: return 32'hD0000001;
            default: return 32'h80000057;
        endcase
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] mask,
                                         input logic d, input logic i);
        logic f;
        f = s[0] ^ d ^ i;
        return (s >> 1) ^ (f ? mask : 32'h0);
    endfunction

    task automatic model_reset();
        ma = 32'h1A5C3E17;
        mb = 32'h6C8E9D31;
        mc = 32'hB7D34A05;
        mphase = 1'b0;
        exp_valid = 1'b0;
    endtask

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic run_cycle(input logic v, input logic b, input string tag);
        logic [31:0] na, nb, nc;
        @(negedge clk);
        check(tag, "cond_valid", cond_valid, exp_valid);
        check(tag, "cond_bit", cond_bit, mc[0]);
        raw_valid = v;
        raw_bit   = b;
        na = ma; nb = mb; nc = mc;
        exp_valid = v && mphase;
        if (v) begin
            na = step(ma, 32'h48000000, b, 1'b0);
            nb = step(mb, mix_mask(ma[1:0]), 1'b0, b);
            if (mphase) nc = step(mc, mix_mask(mb[1:0]), 1'b0, mb[2]);
            mphase = ~mphase;
        end
        ma = na; mb = nb; mc = nc;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        raw_valid = 1'b1;
        raw_bit = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        raw_valid = 1'b0;
        model_reset();
    endtask

    initial begin
        #(CYC * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        do_reset();
        // R1: outputs right after reset
        run_cycle(1'b0, 1'b0, "R1");
        run_cycle(1'b0, 1'b0, "R1");
        // R2 / R8: all zeros, plain feedback only
        for (int k = 0; k < 80; k++) run_cycle(1'b1, 1'b0, "R2");
        // R7: all ones, inverted stage-two feedback on every step
        for (int k = 0; k < 80; k++) run_cycle(1'b1, 1'b1, "R7");
        // R8: alternating pattern walks coefficient indices
        for (int k = 0; k < 80; k++) run_cycle(1'b1, 1'(k & 1), "R8");
        // R3 / R5: dense random stream
        for (int k = 0; k < 2000; k++) run_cycle(1'b1, 1'($urandom_range(0, 1)), "R3");
        // R6 / R4: random gaps in valid
        for (int k = 0; k < 2000; k++)
            run_cycle(1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 1)), "R6");
        // R4: odd count then reset restarts pairing
        run_cycle(1'b1, 1'b1, "R4");
        do_reset();
        run_cycle(1'b0, 1'b0, "R1");
        for (int k = 0; k < 40; k++) run_cycle(1'b1, 1'($urandom_range(0, 1)), "R4");
        // R5: long idle, output must hold
        for (int k = 0; k < 20; k++) run_cycle(1'b0, 1'b1, "R5");
        run_cycle(1'b0, 1'b0, "R5");
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule